// File: doc/BRIEF.md
# Programmable One-Shot and Square-Wave Timer

This block is a 16-bit timer that software configures through a small byte-wide register port and controls through a separate command port. The terminal count N is stored as two byte lanes. A control register holds a mode bit and a pin-routing bit. The command port issues Start, Stop and Clear (Reset). In one-shot mode a Start raises a single event: the output stays high for N clocks, then drops low and remains low. In square-wave mode the output alternates between a high phase of P clocks and a low phase of Q clocks, with P + Q = N, until it is stopped.

Once the timer has been started, its configuration is frozen. Register writes are ignored, and Start is accepted only where the mode allows it. This lasts until a Stop or Clear returns the timer to idle. The timer output can also take over a shared general-purpose pin. While routed, the pin is forced to be an output and carries the timer level. The external direction and level controls regain the pin as soon as routing is switched off.

Top module: `wave_timer`

## Requirements
- R1: After reset `tmr_out` is 1, the timer is idle, every register reads 0, and the pin direction and level pass through from `gp_oe` and `gp_lvl`.
- R2: The register map is as follows. A write to address 0 sets N[7:0], address 1 sets N[15:8], and address 2 sets the control register (bit 0 = square-wave mode, bit 1 = route to pin). Address 3 is the read-only status register (bit 0 = running, bit 1 = `tmr_out`). `rd_data` presents the register selected by `rd_addr` one clock later.
- R3: In one-shot mode, a Start accepted at a clock edge keeps `tmr_out` at 1 for N clocks. The output then goes to 0 and stays at 0.
- R4: In one-shot mode, a Start issued before the timeout restarts the count, so `tmr_out` stays at 1 for N further clocks.
- R5: In one-shot mode, a Start issued after the timeout has no effect. A Stop returns the timer to idle with `tmr_out` = 1, and a later Start runs a new period.
- R6: In square-wave mode `tmr_out` repeats a pattern of P clocks high followed by Q clocks low, where P = floor(N/2) and Q = N − P.
- R7: In square-wave mode, a Start issued while running leaves the waveform unchanged.
- R8: While the timer is running, including after a one-shot timeout, writes to addresses 0 to 2 are ignored and readback returns the stored values.
- R9: The Clear command (code 3) stops the timer, sets `tmr_out` to 1 and zeroes N, the mode bit and the routing bit. Start is code 1 and Stop is code 2.
- R10: With routing on, `pin_oe` is 1 and `pin_out` equals `tmr_out`. With routing off, `pin_oe` = `gp_oe` and `pin_out` = `gp_lvl`.
- R11: A stored N of 0 or 1 behaves as N = 2.
- R12: The status register reports the running flag and the current timer level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | Command: 1 Start, 2 Stop, 3 Clear |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| gp_oe | input | 1 | Pin direction from the general-purpose control |
| gp_lvl | input | 1 | Pin level from the general-purpose control |
| tmr_out | output | 1 | Timer output level |
| pin_oe | output | 1 | Shared pin output enable |
| pin_out | output | 1 | Shared pin drive level |

## Verification
On every cycle, the assertions check these invariants:
- the output is high whenever the timer is idle;
- a Stop always lands in idle with the output high;
- the output never falls while idle;
- an expired one-shot stays low;
- a square-wave phase holds its level until its count ends;
- the configuration stays frozen while running;
- a Clear zeroes every register;
- a routed pin reads high while idle.

Some behaviour can only be shown by the bench scenarios, which compare the output cycle by cycle against computed phase lengths. This covers:
- the exact N-clock one-shot width;
- the asymmetric P/Q split for odd N;
- a full restart before timeout;
- Start being ignored after timeout and during a square wave;
- the clamping of N below 2.

// File: rtl/wave_timer_pkg.sv
package wave_timer_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2,
    CMD_CLEAR = 2'd3
  } tmr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ONESHOT,
    ST_EXPIRED,
    ST_SQUARE
  } tmr_state_e;

  localparam int CTRL_SQ_BIT    = 0;
  localparam int CTRL_ROUTE_BIT = 1;
  localparam int STAT_RUN_BIT   = 0;
  localparam int STAT_OUT_BIT   = 1;

endpackage

// File: rtl/wave_timer_regs.sv
module wave_timer_regs #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_req,
  input  logic              lock,
  output logic [CNT_W-1:0]  n_val,
  output logic              sq_mode,
  output logic              route_en
);
  import wave_timer_pkg::*;

  localparam int LANES     = CNT_W / DATA_W;
  localparam int CTRL_ADDR = LANES;

  logic              wr_ok;
  logic [DATA_W-1:0] lane_q [LANES];

  assign wr_ok = wr_en && !lock && !clr_req;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr_req) begin
        lane_q[g] <= '0;
      end else if (wr_ok && wr_addr == ADDR_W'(g)) begin
        lane_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    n_val = '0;
    for (int i = 0; i < LANES; i++) begin
      n_val[i*DATA_W +: DATA_W] = lane_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_req) begin
      sq_mode  <= 1'b0;
      route_en <= 1'b0;
    end else if (wr_ok && wr_addr == ADDR_W'(CTRL_ADDR)) begin
      sq_mode  <= wr_data[CTRL_SQ_BIT];
      route_en <= wr_data[CTRL_ROUTE_BIT];
    end
  end

  // R8: configuration frozen while the timer is started
  assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (lock && !clr_req) |=> ($stable(n_val) && $stable(sq_mode) && $stable(route_en)));

  // R9: clear wipes every register
  assert_clear_wipes_R9: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (n_val == '0 && !sq_mode && !route_en));

endmodule

// File: rtl/wave_timer_core.sv
module wave_timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             clr_req,
  input  logic             sq_mode,
  input  logic [CNT_W-1:0] n_val,
  output logic             running,
  output logic             tmr_out
);
  import wave_timer_pkg::*;

  localparam logic [CNT_W-1:0] N_MIN = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  tmr_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] n_eff;
  logic [CNT_W-1:0] p_len;
  logic [CNT_W-1:0] q_len;

  always_comb begin
    n_eff = (n_val < N_MIN) ? N_MIN : n_val;
    p_len = n_eff >> 1;
    q_len = n_eff - p_len;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_req || stop_req) begin
      st      <= ST_IDLE;
      tmr_out <= 1'b1;
      cnt     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_req) begin
            tmr_out <= 1'b1;
            if (sq_mode) begin
              st  <= ST_SQUARE;
              cnt <= p_len - ONE;
            end else begin
              st  <= ST_ONESHOT;
              cnt <= n_eff - ONE;
            end
          end
        end
        ST_ONESHOT: begin
          if (start_req) begin
            cnt <= n_eff - ONE;
          end else if (cnt == '0) begin
            tmr_out <= 1'b0;
            st      <= ST_EXPIRED;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_EXPIRED: begin
          st <= ST_EXPIRED;
        end
        ST_SQUARE: begin
          if (cnt == '0) begin
            tmr_out <= ~tmr_out;
            cnt     <= tmr_out ? (q_len - ONE) : (p_len - ONE);
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign running = (st != ST_IDLE);

  // R1: idle always means a high output
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !running |-> tmr_out);

  // R5: stop lands in idle with output high
  assert_stop_idle_R5: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> (!running && tmr_out));

  // R3: a falling output only happens while started
  assert_fall_running_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(tmr_out) |-> running);

  // R5: an expired one-shot stays low until stop or clear
  assert_expired_low_R5: assert property (@(posedge clk) disable iff (rst)
    (running && !sq_mode && !tmr_out && !stop_req && !clr_req) |=> !tmr_out);

  // R6: a square-wave phase holds its level until its count ends
  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (running && sq_mode && cnt != '0 && !stop_req && !clr_req) |=> $stable(tmr_out));

endmodule

// File: rtl/wave_timer_pin.sv
module wave_timer_pin (
  input  logic route_en,
  input  logic tmr_out,
  input  logic gp_oe,
  input  logic gp_lvl,
  output logic pin_oe,
  output logic pin_out
);

  always_comb begin
    if (route_en) begin
      pin_oe  = 1'b1;
      pin_out = tmr_out;
    end else begin
      pin_oe  = gp_oe;
      pin_out = gp_lvl;
    end
  end

endmodule

// File: rtl/wave_timer.sv
module wave_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_code,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              gp_oe,
  input  logic              gp_lvl,
  output logic              tmr_out,
  output logic              pin_oe,
  output logic              pin_out
);
  import wave_timer_pkg::*;

  localparam int LANES     = CNT_W / DATA_W;
  localparam int CTRL_ADDR = LANES;
  localparam int STAT_ADDR = LANES + 1;

  logic             start_req;
  logic             stop_req;
  logic             clr_req;
  logic             running;
  logic             sq_mode;
  logic             route_en;
  logic [CNT_W-1:0] n_val;
  logic [DATA_W-1:0] rd_mux;

  assign start_req = cmd_valid && (cmd_code == CMD_START);
  assign stop_req  = cmd_valid && (cmd_code == CMD_STOP);
  assign clr_req   = cmd_valid && (cmd_code == CMD_CLEAR);

  wave_timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .clr_req  (clr_req),
    .lock     (running),
    .n_val    (n_val),
    .sq_mode  (sq_mode),
    .route_en (route_en)
  );

  wave_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .stop_req  (stop_req),
    .clr_req   (clr_req),
    .sq_mode   (sq_mode),
    .n_val     (n_val),
    .running   (running),
    .tmr_out   (tmr_out)
  );

  wave_timer_pin u_pin (
    .route_en (route_en),
    .tmr_out  (tmr_out),
    .gp_oe    (gp_oe),
    .gp_lvl   (gp_lvl),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_mux = n_val[i*DATA_W +: DATA_W];
    end
    if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_mux[CTRL_SQ_BIT]    = sq_mode;
      rd_mux[CTRL_ROUTE_BIT] = route_en;
    end
    if (rd_addr == ADDR_W'(STAT_ADDR)) begin
      rd_mux[STAT_RUN_BIT] = running;
      rd_mux[STAT_OUT_BIT] = tmr_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R10: a routed pin is an output and reads high while idle
  assert_routed_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (route_en && !running) |-> (pin_oe && pin_out));

endmodule

// File: tb/wave_timer_test.sv
`timescale 1ns/1ps
module wave_timer_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       cmd_valid;
  logic [1:0] cmd_code;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       gp_oe;
  logic       gp_lvl;
  logic       tmr_out;
  logic       pin_oe;
  logic       pin_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  wave_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .rd_addr(rd_addr), .rd_data(rd_data),
    .gp_oe(gp_oe), .gp_lvl(gp_lvl), .tmr_out(tmr_out), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic [1:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    tick();
    cmd_valid = 1'b0; cmd_code = 2'd0;
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(input int n, input bit sq, input bit route);
    do_wr(2'd0, n[7:0]);
    do_wr(2'd1, n[15:8]);
    do_wr(2'd2, {6'd0, route, sq});
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    tick();
    v = int'(rd_data);
  endtask

  function automatic int exp_out(input bit sq, input int n, input int j);
    int ne = (n < 2) ? 2 : n;
    int p  = ne / 2;
    if (!sq) return (j < ne) ? 1 : 0;
    return ((j % ne) < p) ? 1 : 0;
  endfunction

  // start, then compare tmr_out for cycles j = 0 .. cyc-1 after the start edge
  task automatic run_check(input bit sq, input int n, input int cyc, input string req);
    int errs = 0;
    do_cmd(2'd1);
    for (int j = 0; j < cyc; j++) begin
      if (int'(tmr_out) != exp_out(sq, n, j)) begin
        if (errs == 0)
          $display("FAIL %s waveform n=%0d sq=%0d j=%0d actual=%0d expected=%0d",
                   req, n, sq, j, tmr_out, exp_out(sq, n, j));
        errs++;
      end
      tick();
    end
    total++;
    if (errs != 0) bad++;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; cmd_valid = 0; cmd_code = 0;
    rd_addr = 0; gp_oe = 0; gp_lvl = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    check("R1", tmr_out, 1, "tmr_out after reset");
    check("R1", pin_oe, 0, "pin_oe after reset");
    rd(2'd0, v); check("R1", v, 0, "N low after reset");
    rd(2'd2, v); check("R1", v, 0, "ctrl after reset");
    rd(2'd3, v); check("R12", v, 2, "status idle (out=1,run=0)");

    // R2 register map
    set_cfg(16'h1234, 0, 0);
    rd(2'd0, v); check("R2", v, 8'h34, "N low byte");
    rd(2'd1, v); check("R2", v, 8'h12, "N high byte");

    // R3 one-shot
    set_cfg(5, 0, 0);
    run_check(0, 5, 12, "R3");
    rd(2'd3, v); check("R12", v, 1, "status expired (out=0,run=1)");

    // R5 start after timeout ignored, stop restores high
    do_cmd(2'd1);
    repeat (3) tick();
    check("R5", tmr_out, 0, "start after timeout ignored");
    // R8 writes blocked after timeout
    do_wr(2'd0, 8'h77);
    rd(2'd0, v); check("R8", v, 5, "N write blocked after timeout");
    do_cmd(2'd2);
    check("R5", tmr_out, 1, "stop restores high");
    rd(2'd3, v); check("R5", v, 2, "status idle after stop");
    run_check(0, 5, 9, "R5");
    do_cmd(2'd2);

    // R4 restart before timeout
    set_cfg(6, 0, 0);
    do_cmd(2'd1);
    repeat (3) tick();
    run_check(0, 6, 10, "R4");
    do_cmd(2'd2);

    // R6 square, odd/even/minimum
    set_cfg(7, 1, 0);
    run_check(1, 7, 30, "R6");
    do_cmd(2'd2);
    set_cfg(8, 1, 0);
    run_check(1, 8, 30, "R6");
    do_cmd(2'd2);
    set_cfg(2, 1, 0);
    run_check(1, 2, 12, "R6");
    do_cmd(2'd2);
    check("R6", tmr_out, 1, "square stop restores high");

    // R7 start during square ignored
    begin
      int errs = 0;
      set_cfg(9, 1, 0);
      do_cmd(2'd1);
      for (int j = 0; j < 30; j++) begin
        if (int'(tmr_out) != exp_out(1, 9, j)) errs++;
        if (j == 6) begin cmd_valid = 1'b1; cmd_code = 2'd1; end
        tick();
        cmd_valid = 1'b0; cmd_code = 2'd0;
      end
      check("R7", errs, 0, "square waveform mismatches after restart");
    end

    // R8 writes blocked while square running
    do_wr(2'd0, 8'h55);
    do_wr(2'd1, 8'h01);
    do_wr(2'd2, 8'h00);
    rd(2'd0, v); check("R8", v, 9, "N low unchanged while running");
    rd(2'd1, v); check("R8", v, 0, "N high unchanged while running");
    rd(2'd2, v); check("R8", v, 1, "ctrl unchanged while running");

    // R9 clear
    do_cmd(2'd3);
    check("R9", tmr_out, 1, "clear sets out high");
    rd(2'd0, v); check("R9", v, 0, "clear zeroes N");
    rd(2'd2, v); check("R9", v, 0, "clear zeroes ctrl");
    rd(2'd3, v); check("R9", v, 2, "clear leaves idle");

    // R10 routing
    gp_oe = 1; gp_lvl = 0; tick();
    check("R10", {pin_oe, pin_out}, 2, "unrouted passthrough");
    gp_oe = 0;
    set_cfg(3, 0, 1);
    check("R10", {pin_oe, pin_out}, 3, "routed idle forces output high");
    do_cmd(2'd1);
    repeat (3) tick();
    check("R10", {pin_oe, pin_out}, 2, "routed pin follows expired low");
    do_cmd(2'd3);
    gp_lvl = 1; tick();
    check("R10", {pin_oe, pin_out}, 1, "pin returned to general control");

    // R11 clamp below two
    set_cfg(1, 0, 0);
    run_check(0, 1, 6, "R11");
    do_cmd(2'd2);
    set_cfg(0, 1, 0);
    run_check(1, 0, 10, "R11");
    do_cmd(2'd2);

    // random configurations
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 24; it++) begin
      int n  = $urandom_range(0, 40);
      bit sq = $urandom_range(0, 1);
      set_cfg(n, sq, 0);
      run_check(sq, n, 2 * n + 6, sq ? "R6" : "R3");
      do_cmd(2'd2);
      check("R5", tmr_out, 1, "random stop restores high");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule